// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside the receive path of an Ethernet port. For each frame, the frame parser presents the 48-bit destination address together with a one-cycle strobe. Two cycles later the block returns a registered accept or drop decision. Frame parsing, checksum checking and data storage happen elsewhere.

The decision draws on several sources:

- **Exact-match slots.** There are eight of them. Slot 0 is intended for the station's own unicast address and the other slots for multicast groups.
- **Multicast hash table.** It has 64 bits and uses a 6-bit XOR fold of the address as its index.
- **Accept-all mode.** When set, every frame is accepted.
- **Broadcast-reject mode.** When set, the all-ones address is refused.

A simple register-style write port loads the slots, the two hash words and the mode bits. Each slot is loaded as a low word and then a high word. A low-word write closes exact matching for all slots, and the next high-word write opens it again. Software can therefore rewrite the slots without a half-updated address being matched.

The address input is a valid-only stream. The block has no ready signal and never applies back-pressure. It accepts one address every cycle, and its pipeline never stalls. The decision output is also valid-only, and the consumer must take it in the cycle it is shown. Configuration writes must land at least two cycles before a strobe that is meant to see them.

Top module: `rx_addr_filter`

## Requirements
- R1: For every cycle with `da_valid` high, `dec_valid` is high for exactly one cycle two cycles later, with back-to-back strobes producing back-to-back decisions. `dec_valid` is low in every other cycle, and `dec_accept` is never high while `dec_valid` is low.
- R2: Slot k takes its low word at `cfg_addr` = 2k and its high word at 2k+1. The low word holds address bits 31:0, where `da_addr[7:0]` is byte 0, the first byte on the wire. Bits 15:0 of the high word hold address bits 47:32. While exact matching is open, an address equal to any slot is accepted.
- R3: The hash index of an address is 6 bits wide. For each address bit n from 0 to 47, the bit is XORed into index bit (n mod 6). Word `cfg_addr` = 16 holds table bits for indices 0 to 31, with bit i standing for index i. Word 17 holds the bits for indices 32 to 63, with bit i standing for index 32+i. A group address (`da_addr[0]` = 1) whose table bit is set is accepted.
- R4: The hash table has no effect on individual addresses (`da_addr[0]` = 0). Such an address is dropped unless a slot matches it or accept-all is set.
- R5: Bit 0 of the mode word (`cfg_addr` = 18) selects accept-all. When it is set, every address is accepted, including the all-ones address while broadcast-reject is on.
- R6: With both hash words set to all ones, every group address is accepted, including the all-ones address when broadcast-reject is off.
- R7: Bit 1 of the mode word selects broadcast-reject. When it is set and accept-all is clear, the all-ones address is dropped.
- R8: A write to any slot's low word closes exact matching for all slots, and a write to any slot's high word opens it. Exact matching is closed after reset, with slots, hash table and mode cleared.
- R9: While reset is active and immediately after it, `dec_valid` and `dec_accept` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word select (slots 0..15, hash 16/17, mode 18) |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe from the parser |
| da_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Decision valid, two cycles after `da_valid` |
| dec_accept | output | 1 | 1 = accept frame, 0 = drop |

## Verification
Every decision is due on the second rising edge after the edge that samples its strobe. The bench drives a strobe just after a falling edge and reads the result at the second falling edge after that. It also confirms that `dec_valid` is still low one falling edge earlier. For back-to-back strobes, the two results are read on consecutive falling edges. Configuration writes are followed by idle cycles, so no decision overlaps a change to the settings it depends on.

// File: rtl/raf_pkg.sv
package raf_pkg;
  localparam int MAC_W  = 48;
  localparam int HIDX_W = 6;
  localparam int HTAB_W = 1 << HIDX_W;
  localparam int WORD_W = 32;

  typedef logic [MAC_W-1:0]  mac_t;
  typedef logic [HIDX_W-1:0] hidx_t;

  typedef struct packed {
    logic bcast_off;
    logic promisc;
  } mode_t;
endpackage

// File: rtl/raf_cfg_regs.sv
module raf_cfg_regs
  import raf_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CFG_AW    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [WORD_W-1:0]   cfg_wdata,
  output mac_t                slot_q [NUM_SLOTS],
  output logic [HTAB_W-1:0]   htab_q,
  output mode_t               mode_q,
  output logic                exact_en_q
);
  localparam logic [CFG_AW-1:0] A_SLOT_END = CFG_AW'(2 * NUM_SLOTS);
  localparam logic [CFG_AW-1:0] A_HASH_LO  = CFG_AW'(2 * NUM_SLOTS);
  localparam logic [CFG_AW-1:0] A_HASH_HI  = CFG_AW'(2 * NUM_SLOTS + 1);
  localparam logic [CFG_AW-1:0] A_MODE     = CFG_AW'(2 * NUM_SLOTS + 2);

  logic slot_wr;
  assign slot_wr = cfg_we && (cfg_addr < A_SLOT_END);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [CFG_AW-1:0] A_LO = CFG_AW'(2 * k);
    localparam logic [CFG_AW-1:0] A_HI = CFG_AW'(2 * k + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[k] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == A_LO) slot_q[k][31:0]  <= cfg_wdata;
        if (cfg_addr == A_HI) slot_q[k][47:32] <= cfg_wdata[15:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      htab_q     <= '0;
      mode_q     <= '0;
      exact_en_q <= 1'b0;
    end else begin
      if (slot_wr) exact_en_q <= cfg_addr[0];
      if (cfg_we && cfg_addr == A_HASH_LO) htab_q[31:0]  <= cfg_wdata;
      if (cfg_we && cfg_addr == A_HASH_HI) htab_q[63:32] <= cfg_wdata;
      if (cfg_we && cfg_addr == A_MODE)    mode_q        <= mode_t'(cfg_wdata[1:0]);
    end
  end
endmodule

// File: rtl/raf_exact.sv
module raf_exact
  import raf_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  mac_t da,
  input  mac_t slot_q [NUM_SLOTS],
  input  logic exact_en,
  output logic hit
);
  logic [NUM_SLOTS-1:0] eq;
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cmp
    assign eq[k] = (da == slot_q[k]);
  end
  assign hit = exact_en && (|eq);
endmodule

// File: rtl/raf_hash.sv
module raf_hash
  import raf_pkg::*;
(
  input  mac_t  da,
  output hidx_t idx
);
  always_comb begin
    idx = '0;
    for (int n = 0; n < MAC_W; n++) begin
      idx[n % HIDX_W] = idx[n % HIDX_W] ^ da[n];
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import raf_pkg::*;
#(
  parameter  int NUM_SLOTS = 8,
  localparam int CFG_AW    = $clog2(2 * NUM_SLOTS + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              da_valid,
  input  logic [47:0]       da_addr,
  output logic              dec_valid,
  output logic              dec_accept
);
  mac_t              slot_q [NUM_SLOTS];
  logic [HTAB_W-1:0] htab_q;
  mode_t             mode_q;
  logic              exact_en;
  logic              hit_c;
  hidx_t             hidx_c;

  raf_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .slot_q(slot_q), .htab_q(htab_q),
    .mode_q(mode_q), .exact_en_q(exact_en)
  );

  raf_exact #(.NUM_SLOTS(NUM_SLOTS)) u_exact (
    .da(da_addr), .slot_q(slot_q), .exact_en(exact_en), .hit(hit_c)
  );

  raf_hash u_hash (.da(da_addr), .idx(hidx_c));

  // stage 1: match results and address class
  logic  s1_valid, s1_hit, s1_group, s1_bcast;
  hidx_t s1_hidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_group <= 1'b0;
      s1_bcast <= 1'b0;
      s1_hidx  <= '0;
    end else begin
      s1_valid <= da_valid;
      s1_hit   <= hit_c;
      s1_group <= da_addr[0];
      s1_bcast <= &da_addr;
      s1_hidx  <= hidx_c;
    end
  end

  // stage 2: combine with hash table and modes
  logic promisc, bcast_off, accept_c;
  assign promisc   = mode_q.promisc;
  assign bcast_off = mode_q.bcast_off;
  assign accept_c  = promisc ||
                     (!(s1_bcast && bcast_off) &&
                      (s1_hit || (s1_group && htab_q[s1_hidx])));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= s1_valid;
      dec_accept <= s1_valid && accept_c;
    end
  end
endmodule

// File: rtl/raf_checker.sv
module raf_checker #(
  parameter int NUM_SLOTS = 8,
  parameter int CFG_AW    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic              da_valid,
  input logic              dec_valid,
  input logic              dec_accept,
  input logic              exact_en,
  input logic              promisc,
  input logic              bcast_off,
  input logic              s1_valid,
  input logic              s1_group,
  input logic              s1_bcast,
  input logic              s1_hit
);
  localparam logic [CFG_AW-1:0] SLOT_END = CFG_AW'(2 * NUM_SLOTS);

  AST_DEC_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> ##1 dec_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> ##1 !dec_valid); // R1
  AST_ACCEPT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid); // R1
  AST_PROMISC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && promisc) |=> dec_accept); // R5
  AST_BCAST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_bcast && bcast_off && !promisc) |=> !dec_accept); // R7
  AST_UCAST_NOHASH: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_group && !s1_hit && !promisc) |=> !dec_accept); // R4
  AST_GATE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr < SLOT_END && !cfg_addr[0]) |=> !exact_en); // R8
  AST_GATE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr < SLOT_END && cfg_addr[0]) |=> exact_en); // R8
endmodule

bind rx_addr_filter raf_checker #(.NUM_SLOTS(NUM_SLOTS), .CFG_AW(CFG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .da_valid(da_valid), .dec_valid(dec_valid), .dec_accept(dec_accept),
  .exact_en(exact_en), .promisc(promisc), .bcast_off(bcast_off),
  .s1_valid(s1_valid), .s1_group(s1_group), .s1_bcast(s1_bcast),
  .s1_hit(s1_hit)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        da_valid = 1'b0;
  logic [47:0] da_addr = '0;
  logic        dec_valid, dec_accept;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rx_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_addr(da_addr),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // {address, expected accept} with slot0, slot3 loaded and hash bits 1, 33 set
  localparam logic [48:0] VEC [8] = '{
    {48'h554433221102, 1'b1},  // R2 slot 0 unicast
    {48'h564433221102, 1'b0},  // R4 unicast, no slot
    {48'h000000000001, 1'b1},  // R3 index 1, low word
    {48'h000000000003, 1'b0},  // R3 index 3 not set
    {48'h800000000001, 1'b1},  // R3 index 33, high word
    {48'h0100005e0001, 1'b1},  // R2 slot 3 multicast
    {48'hffffffffffff, 1'b0},  // R3 all ones folds to index 0
    {48'h000000000040, 1'b0}   // R4 unicast hashing to index 1
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input string req, input logic [47:0] da, input logic exp);
    @(negedge clk);
    da_valid = 1'b1; da_addr = da;
    @(negedge clk);
    da_valid = 1'b0;
    check({req, " early"}, dec_valid, 1'b0);
    @(negedge clk);
    check({req, " valid"}, dec_valid, 1'b1);
    check({req, " accept"}, dec_accept, exp);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid", dec_valid, 1'b0);
    check("R9 reset accept", dec_accept, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", dec_valid, 1'b0);

    send("R8 closed after reset", 48'h0, 1'b0);

    wr(5'd0, 32'h33221102); wr(5'd1, 32'h00005544);
    wr(5'd6, 32'h005e0001); wr(5'd7, 32'h00000100);
    wr(5'd16, 32'h00000002); wr(5'd17, 32'h00000002);

    for (int i = 0; i < 8; i++) begin
      send($sformatf("R2/R3/R4 vec%0d", i), VEC[i][48:1], VEC[i][0]);
    end

    // R8 gating by low/high word writes of another slot
    wr(5'd10, 32'h0);
    send("R8 gated", 48'h554433221102, 1'b0);
    wr(5'd11, 32'h0);
    send("R8 reopened", 48'h554433221102, 1'b1);

    // R1 back-to-back strobes
    @(negedge clk);
    da_valid = 1'b1; da_addr = 48'h554433221102;
    @(negedge clk);
    da_addr = 48'h000000000003;
    @(negedge clk);
    da_valid = 1'b0;
    check("R1 b2b first valid", dec_valid, 1'b1);
    check("R1 b2b first accept", dec_accept, 1'b1);
    @(negedge clk);
    check("R1 b2b second valid", dec_valid, 1'b1);
    check("R1 b2b second accept", dec_accept, 1'b0);
    @(negedge clk);
    check("R1 idle", dec_valid, 1'b0);

    // R5 accept-all
    wr(5'd18, 32'h1);
    send("R5 unicast", 48'h564433221102, 1'b1);
    send("R5 group", 48'h000000000003, 1'b1);
    wr(5'd18, 32'h3);
    send("R5 over bcast reject", 48'hffffffffffff, 1'b1);

    // R6 / R7
    wr(5'd16, 32'hffffffff); wr(5'd17, 32'hffffffff);
    wr(5'd18, 32'h0);
    send("R6 broadcast", 48'hffffffffffff, 1'b1);
    send("R6 group", 48'h000000000003, 1'b1);
    send("R4 unicast all-ones table", 48'h000000000040, 1'b0);
    wr(5'd18, 32'h2);
    send("R7 broadcast drop", 48'hffffffffffff, 1'b0);
    send("R7 group still", 48'h000000000003, 1'b1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule